// File: doc/BRIEF.md
# Partial-Store Edge Mask Generator

This unit turns a pair of byte addresses into the write-enable mask for the edge of a partial store. The addresses are a start and an end pointer. The mask covers the part of the 8-byte-aligned block holding the start address that lies on or after the start. When the end address falls in that same block, the mask is also cut off after the end. Elements can be bytes, halfwords or words. The lanes can be numbered big-endian, with the lowest address on the most significant mask bit, or little-endian, with the lowest address on the least significant bit.

The unit also works out integer condition flags for the subtraction start minus end. It produces one set for the full 64-bit difference and one set for its low 32 bits. A flag register changes only for operation codes that ask for a condition-code update. An address-mask mode input limits the same-block comparison to the low 32 bits of the addresses. Operation codes outside the valid set raise an illegal indication and change nothing else. Results are captured on a clock edge while the valid strobe is high.

Top module: `edge_mask_unit`

## Requirements
- R1: The 4-bit operation code is decoded as follows. Bits 3:2 give the element width: 0 for bytes (8-bit mask), 1 for halfwords (4-bit mask), 2 for words (2-bit mask). Bit 1 set selects little-endian lane numbering. Bit 0 set suppresses the flag update. Codes 0x0 to 0xB are legal.
- R2: In byte mode the element offset is address bits 2:0. With N = 8 mask bits and offset o, mask bit k is active as follows. Big-endian left mask: N-1-k >= o. Big-endian right mask: N-1-k <= o. Little-endian left mask: k >= o. Little-endian right mask: k <= o.
- R3: In halfword mode the offset is address bits 2:1, and the R2 rules apply with N = 4.
- R4: In word mode the offset is address bit 2, and the R2 rules apply with N = 2. Bits 63:2 of the result are zero.
- R5: The left mask uses the start offset and the right mask uses the end offset. If the aligned blocks (address bits 2:0 cleared) are equal, the result is left AND right. Otherwise the result is the left mask alone. The result is zero-extended to 64 bits.
- R6: When address-mask mode is high, bits 63:32 are also ignored in the block comparison.
- R7: The 64-bit flags are ordered [3]=N, [2]=Z, [1]=V, [0]=C and describe start minus end. N is the sign of the difference, Z is set for a zero difference, V is signed overflow, and C is the unsigned borrow (start < end).
- R8: The 32-bit flags use the same bit order and describe the difference of the low 32 bits of the two addresses.
- R9: A legal code with bit 0 set updates the mask but leaves both flag outputs unchanged.
- R10: A code above 0xB sets the illegal output and leaves the mask and both flag outputs unchanged. A legal code clears the illegal output.
- R11: Outputs change only at a rising edge where valid is high, and they show that edge's result from then on. With valid low, every output holds.
- R12: After reset the mask, both flag sets and the illegal output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Capture strobe |
| opSel | input | 4 | Operation code: width, lane order, flag suppression |
| addrMaskMode | input | 1 | Limit block comparison to 32 bits |
| startAddr | input | 64 | Start address |
| endAddr | input | 64 | End address |
| maskOut | output | 64 | Zero-extended edge mask |
| flags64 | output | 4 | N, Z, V, C of the 64-bit difference |
| flags32 | output | 4 | N, Z, V, C of the 32-bit difference |
| illegalOut | output | 1 | Last captured operation code was illegal |

## Verification
Every result passes through a single register stage. The mask, both flag sets and the illegal output therefore all change at the first rising edge where valid is high and are due one cycle after the inputs are applied. The bench drives the inputs on a falling edge and checks the outputs on the next falling edge, half a cycle after the capture edge. This avoids any race with the registers. Idle cycles are checked the same way to confirm that nothing moves when valid is low.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  localparam logic [3:0] LAST_LEGAL_OP = 4'hB;

  typedef enum logic [1:0] {
    WIDTH_BYTE = 2'd0,
    WIDTH_HALF = 2'd1,
    WIDTH_WORD = 2'd2,
    WIDTH_NONE = 2'd3
  } widthSel_e;

  typedef struct packed {
    logic      capture;
    logic      load;
    logic      ccWrite;
    logic      littleEnd;
    widthSel_e widthSel;
    logic      illegal;
  } edgeCtrl_t;

endpackage

// File: rtl/edge_mask_ctrl.sv
module edge_mask_ctrl
  import edge_mask_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] opSel,
  output edgeCtrl_t  ctrl
);

  logic legalOp;

  assign legalOp = (opSel <= LAST_LEGAL_OP);

  always_comb begin
    ctrl.capture   = valid;
    ctrl.load      = valid & legalOp;
    ctrl.ccWrite   = valid & legalOp & ~opSel[0];
    ctrl.littleEnd = opSel[1];
    ctrl.widthSel  = widthSel_e'(opSel[3:2]);
    ctrl.illegal   = ~legalOp;
  end

endmodule

// File: rtl/edge_mask_dp.sv
module edge_mask_dp
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LOW_W   = 32,
  parameter int BLOCK_B = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  edgeCtrl_t         ctrl,
  input  logic              addrMaskMode,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  output logic [ADDR_W-1:0] maskOut,
  output logic [3:0]        flags64,
  output logic [3:0]        flags32,
  output logic              illegalOut
);

  localparam int LANES = 1 << BLOCK_B;
  localparam int WIDTHS = 3;
  localparam logic [ADDR_W-1:0] BLOCK_MASK = ~ADDR_W'(LANES - 1);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'({LOW_W{1'b1}}) & BLOCK_MASK;

  logic [LANES-1:0] leftCand [WIDTHS];
  logic [LANES-1:0] rightCand [WIDTHS];

  for (genvar g = 0; g < WIDTHS; g++) begin : gWidth
    localparam int ELEMS = LANES >> g;
    localparam logic [LANES-1:0] ONES = LANES'((1 << ELEMS) - 1);
    localparam logic [BLOCK_B-1:0] TOP_IDX = BLOCK_B'(ELEMS - 1);

    logic [BLOCK_B-1:0] sOff, eOff;
    logic [LANES-1:0] leftBe, rightBe, leftLe, rightLe;

    assign sOff    = BLOCK_B'(startAddr[BLOCK_B-1:0] >> g);
    assign eOff    = BLOCK_B'(endAddr[BLOCK_B-1:0] >> g);
    assign leftBe  = ONES >> sOff;
    assign rightBe = (ONES << (TOP_IDX - eOff)) & ONES;
    assign leftLe  = (ONES << sOff) & ONES;
    assign rightLe = ONES >> (TOP_IDX - eOff);

    assign leftCand[g]  = ctrl.littleEnd ? leftLe : leftBe;
    assign rightCand[g] = ctrl.littleEnd ? rightLe : rightBe;
  end

  logic [LANES-1:0] leftMask, rightMask, edgeMask;
  logic [ADDR_W-1:0] cmpMask;
  logic sameBlock;

  always_comb begin
    case (ctrl.widthSel)
      WIDTH_BYTE: begin leftMask = leftCand[0]; rightMask = rightCand[0]; end
      WIDTH_HALF: begin leftMask = leftCand[1]; rightMask = rightCand[1]; end
      WIDTH_WORD: begin leftMask = leftCand[2]; rightMask = rightCand[2]; end
      default:    begin leftMask = '0;          rightMask = '0;           end
    endcase
  end

  assign cmpMask   = addrMaskMode ? LOW_MASK : BLOCK_MASK;
  assign sameBlock = ((startAddr & cmpMask) == (endAddr & cmpMask));
  assign edgeMask  = sameBlock ? (leftMask & rightMask) : leftMask;

  logic [3:0] flagsNext [2];

  for (genvar v = 0; v < 2; v++) begin : gView
    localparam int VW = (v == 0) ? ADDR_W : LOW_W;
    logic [VW:0] diffExt;
    logic aSign, bSign, dSign;

    assign diffExt = {1'b0, startAddr[VW-1:0]} - {1'b0, endAddr[VW-1:0]};
    assign aSign   = startAddr[VW-1];
    assign bSign   = endAddr[VW-1];
    assign dSign   = diffExt[VW-1];

    always_comb begin
      flagsNext[v] = '0;
      flagsNext[v][FLAG_N] = dSign;
      flagsNext[v][FLAG_Z] = ~|diffExt[VW-1:0];
      flagsNext[v][FLAG_V] = (aSign ^ bSign) & (dSign ^ aSign);
      flagsNext[v][FLAG_C] = diffExt[VW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskOut    <= '0;
      flags64    <= '0;
      flags32    <= '0;
      illegalOut <= 1'b0;
    end else begin
      if (ctrl.capture) illegalOut <= ctrl.illegal;
      if (ctrl.load)    maskOut <= {{(ADDR_W-LANES){1'b0}}, edgeMask};
      if (ctrl.ccWrite) begin
        flags64 <= flagsNext[0];
        flags32 <= flagsNext[1];
      end
    end
  end

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(maskOut) && $stable(flags64) && $stable(flags32) && $stable(illegalOut)));

  assert_illegal_keeps_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ctrl.illegal) |=> ($stable(maskOut) && $stable(flags64) && $stable(flags32) && illegalOut));

  assert_nocc_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.ccWrite) |=> ($stable(flags64) && $stable(flags32)));

  assert_word_mask_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.widthSel == WIDTH_WORD) |=> (maskOut[ADDR_W-1:2] == '0));

  assert_equal_sets_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.ccWrite && startAddr == endAddr) |=> (flags64[FLAG_Z] && flags32[FLAG_Z] && !flags64[FLAG_C]));

endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [3:0]        opSel,
  input  logic              addrMaskMode,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  output logic [ADDR_W-1:0] maskOut,
  output logic [3:0]        flags64,
  output logic [3:0]        flags32,
  output logic              illegalOut
);

  edgeCtrl_t ctrl;

  edge_mask_ctrl uCtrl (
    .valid (valid),
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  edge_mask_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .addrMaskMode (addrMaskMode),
    .startAddr    (startAddr),
    .endAddr      (endAddr),
    .maskOut      (maskOut),
    .flags64      (flags64),
    .flags32      (flags32),
    .illegalOut   (illegalOut)
  );

endmodule

// File: tb/edge_mask_unit_test.sv
module edge_mask_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  opSel = '0;
  logic        addrMaskMode = 1'b0;
  logic [63:0] startAddr = '0;
  logic [63:0] endAddr = '0;
  logic [63:0] maskOut;
  logic [3:0]  flags64, flags32;
  logic        illegalOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [63:0] expMaskReg = '0;
  logic [3:0]  expF64 = '0, expF32 = '0;
  logic        expIll = 1'b0;

  always #2 clk = ~clk;

  edge_mask_unit uut (
    .clk(clk), .rstN(rstN), .valid(valid), .opSel(opSel),
    .addrMaskMode(addrMaskMode), .startAddr(startAddr), .endAddr(endAddr),
    .maskOut(maskOut), .flags64(flags64), .flags32(flags32), .illegalOut(illegalOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] modelMask(input logic [3:0] op, input logic [63:0] s,
                                            input logic [63:0] e, input logic amm);
    int g = int'(op[3:2]);
    int n = 8 >> g;
    int so = int'(s[2:0]) >> g;
    int eo = int'(e[2:0]) >> g;
    bit le = op[1];
    logic [63:0] lm = '0, rm = '0;
    bit same;
    for (int k = 0; k < n; k++) begin
      int pos = le ? k : (n - 1 - k);
      if (pos >= so) lm[k] = 1'b1;
      if (pos <= eo) rm[k] = 1'b1;
    end
    same = amm ? (s[31:3] == e[31:3]) : (s[63:3] == e[63:3]);
    return same ? (lm & rm) : lm;
  endfunction

  function automatic logic [3:0] model64(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] wide = {a[63], a} - {b[63], b};
    logic [63:0] d = a - b;
    return {d[63], (a == b), (wide[64] != wide[63]), (a < b)};
  endfunction

  function automatic logic [3:0] model32(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] wide = {a[31], a} - {b[31], b};
    logic [31:0] d = a - b;
    return {d[31], (a == b), (wide[32] != wide[31]), (a < b)};
  endfunction

  task automatic checkAll(input logic [3:0] op);
    string tag;
    case (op[3:2])
      2'd0: tag = "R2/R5";
      2'd1: tag = "R3/R5";
      default: tag = "R4/R5";
    endcase
    if (op > 4'hB) tag = "R10 mask";
    check(tag, maskOut, expMaskReg);
    check(op[0] ? "R9 flags64" : "R7 flags64", {60'd0, flags64}, {60'd0, expF64});
    check(op[0] ? "R9 flags32" : "R8 flags32", {60'd0, flags32}, {60'd0, expF32});
    check("R10 illegal", {63'd0, illegalOut}, {63'd0, expIll});
  endtask

  task automatic applyOp(input logic [3:0] op, input logic [63:0] s, input logic [63:0] e,
                         input logic amm);
    opSel = op; startAddr = s; endAddr = e; addrMaskMode = amm; valid = 1'b1;
    expIll = (op > 4'hB);
    if (op <= 4'hB) begin
      expMaskReg = modelMask(op, s, e, amm);
      if (!op[0]) begin
        expF64 = model64(s, e);
        expF32 = model32(s[31:0], e[31:0]);
      end
    end
    @(negedge clk);
    valid = 1'b0;
    checkAll(op);
  endtask

  initial begin
    logic [63:0] sBase [4];
    logic [63:0] eBase [4];
    logic        ammSel [4];
    sBase[0] = 64'h0123_4567_89AB_CD00; eBase[0] = 64'h0123_4567_89AB_CD00; ammSel[0] = 1'b0;
    sBase[1] = 64'h7FFF_FFFF_7FFF_FF00; eBase[1] = 64'h8000_0000_8000_0040; ammSel[1] = 1'b0;
    sBase[2] = 64'hFFFF_0000_1234_5600; eBase[2] = 64'h0000_1111_1234_5600; ammSel[2] = 1'b1;
    sBase[3] = 64'hFFFF_0000_1234_5600; eBase[3] = 64'h0000_1111_1234_5600; ammSel[3] = 1'b0;

    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 mask", maskOut, 64'd0);
    check("R12 flags", {56'd0, flags64, flags32}, 64'd0);
    check("R12 illegal", {63'd0, illegalOut}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1..R10: sweep every code, every start/end offset, four address scenarios
    for (int sc = 0; sc < 4; sc++)
      for (int op = 0; op < 16; op++)
        for (int so = 0; so < 8; so++)
          for (int eo = 0; eo < 8; eo++)
            applyOp(4'(op), sBase[sc] | 64'(so), eBase[sc] | 64'(eo), ammSel[sc]);

    // R6: same low 32 bits, different high half, compared with and without mask mode
    applyOp(4'h0, 64'hAAAA_0000_0000_1003, 64'h5555_0000_0000_1005, 1'b1);
    check("R6 masked compare", maskOut, 64'h0000_0000_0000_1F1C >> 8 & 64'h1C);
    applyOp(4'h0, 64'hAAAA_0000_0000_1003, 64'h5555_0000_0000_1005, 1'b0);
    check("R6 full compare", maskOut, 64'h1F);

    // R11: valid low, inputs moving, nothing changes
    applyOp(4'h2, 64'h10, 64'h30, 1'b0);
    for (int i = 0; i < 8; i++) begin
      opSel = 4'(i); startAddr = 64'(i * 13); endAddr = 64'(i * 7 + 100); valid = 1'b0;
      @(negedge clk);
      check("R11 idle mask", maskOut, expMaskReg);
      check("R11 idle flags", {56'd0, flags64, flags32}, {56'd0, expF64, expF32});
      check("R11 idle illegal", {63'd0, illegalOut}, {63'd0, expIll});
    end

    // R10: illegal code after a legal one, then a legal code clears it
    applyOp(4'hF, 64'h0, 64'hFFFF, 1'b0);
    applyOp(4'h8, 64'h4, 64'h4, 1'b0);
    check("R4 word mask same block", maskOut, 64'h1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule